// File: doc/BRIEF.md
# Display Bias Supply Power-Up Sequencer

This block supervises the start and stop of a multi-rail display bias supply. Its inputs are digital flags from analog comparators: an input-voltage rising-threshold flag, an input-voltage falling-threshold flag, a reference-good flag, one soft-start-complete flag per regulator, a fault flag and a flag for the delay-capacitor threshold. Its outputs are the regulator enables, the amplifier high-impedance control, the charge and discharge controls for the delay capacitor, and the gate controls for the output switch stage. The switch stage has two pass switches of different strength and a pulldown on the common node.

The rising and falling input flags together form a hysteresis latch. Once the input is good, the block waits for the reference and then enables every regulator in the same cycle. When all soft-starts are done and no fault is present, it starts charging the delay capacitor. The switch stage is unlocked only after the delay flag also asserts. While the stage is unlocked, a synchronized steering input picks which pass switch conducts. Every change between the two switches goes through one clock with both switches off. A fault drops the stage and re-arms the delay. An input undervoltage shuts everything down.

Top module: `bias_sequencer`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), all regEn bits are 0, ampHiZ=1, delayDischarge=1, delayCharge=0, srcSwOn=0, drnSwOn=0 and comPulldown=1.
- R2: The block leaves the off state only after uvRiseOk has been seen high (a one-cycle pulse is enough). The regulators are enabled two edges after that. With both flags low, the last state is kept. uvFallLow has priority when both flags are high.
- R3: In the reference-wait state, all NUM_REG bits of regEn rise together on the edge that samples refReady high, and ampHiZ falls on that same edge.
- R4: On the edge that samples uvFallLow high, regEn becomes 0, ampHiZ becomes 1 and delayDischarge becomes 1. Both switches turn off and comPulldown turns on one edge later. The block then stays off until uvRiseOk is seen again.
- R5: delayCharge=1 and delayDischarge=0 happen only after an edge that samples every ssDone bit high and faultIn low. Until then delayDischarge=1 and delayCharge=0.
- R6: The switch stage unlocks only after an edge in the delay state that samples delayReached=1, all ssDone bits high, faultIn=0 and uvFallLow=0. Before that, ctlIn has no effect: srcSwOn=0, drnSwOn=0 and comPulldown=1. Once the stage is unlocked, comPulldown goes low one edge later.
- R7: While the stage is unlocked, a synchronized ctlIn of 1 selects srcSwOn=1 with drnSwOn=0, and 0 selects drnSwOn=1 with srcSwOn=0. ctlIn passes through SYNC_STAGES flops. A change at ctlIn turns the old switch off SYNC_STAGES+1 edges later and turns the new switch on one edge after that.
- R8: srcSwOn and drnSwOn are never 1 together. A switch never turns on in the cycle right after the other switch was on.
- R9: A faultIn, or any ssDone bit dropping, after unlock returns the block to the soft-start state. On that edge delayDischarge=1 and delayCharge=0, and the switches turn off one edge later. When the conditions hold again, the delay recharges and the stage unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| uvRiseOk | input | 1 | Input above rising threshold |
| uvFallLow | input | 1 | Input below falling threshold |
| refReady | input | 1 | Reference above its ready level |
| ssDone | input | NUM_REG | Soft-start complete, one per regulator |
| faultIn | input | 1 | Fault present |
| delayReached | input | 1 | Delay capacitor above threshold |
| ctlIn | input | 1 | Asynchronous switch steering input |
| regEn | output | NUM_REG | Regulator enables |
| ampHiZ | output | 1 | Amplifier outputs high impedance |
| delayCharge | output | 1 | Enable delay capacitor charge current |
| delayDischarge | output | 1 | Hold delay capacitor discharged |
| srcSwOn | output | 1 | Gate of the common-to-source switch |
| drnSwOn | output | 1 | Gate of the drain-to-common switch |
| comPulldown | output | 1 | Common node pulldown enable |

## Verification
The bench builds the block with the default values: NUM_REG=3 regulators and SYNC_STAGES=2. With NUM_REG=3, a partial soft-start pattern such as 3'b011 can be shown to block delay charging. With SYNC_STAGES=2, the exact edge at which a steering change reaches the switches can be pinned down. That makes the break-before-make gap visible as a single cycle with both switches off.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF       = 3'd0,
    SEQ_REF_WAIT  = 3'd1,
    SEQ_SOFTSTART = 3'd2,
    SEQ_DELAY     = 3'd3,
    SEQ_ACTIVE    = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic regOn;     // regulators and amplifiers running
    logic chargeOn;  // delay capacitor may charge
    logic stageEn;   // switch stage unlocked
  } seqStrobes_t;

endpackage

// File: rtl/bias_seq_ctrl.sv
module bias_seq_ctrl
  import bias_seq_pkg::*;
#(
  parameter int NUM_REG = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               uvRiseOk,
  input  logic               uvFallLow,
  input  logic               refReady,
  input  logic [NUM_REG-1:0] ssDone,
  input  logic               faultIn,
  input  logic               delayReached,
  output seqStrobes_t        strobes
);

  seqState_t state;
  seqState_t nextState;
  logic      inputGood;
  logic      allDone;

  assign allDone = &ssDone;

  // Hysteresis latch: falling flag wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inputGood <= 1'b0;
    end else if (uvFallLow) begin
      inputGood <= 1'b0;
    end else if (uvRiseOk) begin
      inputGood <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    if (state == SEQ_OFF) begin
      if (inputGood && !uvFallLow) nextState = SEQ_REF_WAIT;
    end else if (uvFallLow) begin
      nextState = SEQ_OFF;
    end else begin
      case (state)
        SEQ_REF_WAIT: begin
          if (refReady) nextState = SEQ_SOFTSTART;
        end
        SEQ_SOFTSTART: begin
          if (allDone && !faultIn) nextState = SEQ_DELAY;
        end
        SEQ_DELAY: begin
          if (faultIn || !allDone) nextState = SEQ_SOFTSTART;
          else if (delayReached)   nextState = SEQ_ACTIVE;
        end
        SEQ_ACTIVE: begin
          if (faultIn || !allDone) nextState = SEQ_SOFTSTART;
        end
        default: nextState = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobes.regOn    = (state == SEQ_SOFTSTART) || (state == SEQ_DELAY) ||
                       (state == SEQ_ACTIVE);
    strobes.chargeOn = (state == SEQ_DELAY) || (state == SEQ_ACTIVE);
    strobes.stageEn  = (state == SEQ_ACTIVE);
  end

endmodule

// File: rtl/bias_seq_datapath.sv
module bias_seq_datapath
  import bias_seq_pkg::*;
#(
  parameter int NUM_REG     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strobes,
  input  logic               ctlIn,
  output logic [NUM_REG-1:0] regEn,
  output logic               ampHiZ,
  output logic               delayCharge,
  output logic               delayDischarge,
  output logic               srcSwOn,
  output logic               drnSwOn,
  output logic               comPulldown
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   ctlSync;

  // Steering input synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= ctlIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], ctlIn};
      end
    end
  endgenerate

  assign ctlSync = syncChain[LAST_STAGE];

  // Per-regulator enable fan-out
  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : g_regEn
      assign regEn[g] = strobes.regOn;
    end
  endgenerate

  assign ampHiZ         = !strobes.regOn;
  assign delayCharge    = strobes.chargeOn;
  assign delayDischarge = !strobes.chargeOn;

  // Break-before-make: a switch may close only if the other was open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSwOn     <= 1'b0;
      drnSwOn     <= 1'b0;
      comPulldown <= 1'b1;
    end else begin
      srcSwOn     <= strobes.stageEn &&  ctlSync && !drnSwOn;
      drnSwOn     <= strobes.stageEn && !ctlSync && !srcSwOn;
      comPulldown <= !strobes.stageEn;
    end
  end

endmodule

// File: rtl/bias_sequencer.sv
module bias_sequencer
  import bias_seq_pkg::*;
#(
  parameter int NUM_REG     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               uvRiseOk,
  input  logic               uvFallLow,
  input  logic               refReady,
  input  logic [NUM_REG-1:0] ssDone,
  input  logic               faultIn,
  input  logic               delayReached,
  input  logic               ctlIn,
  output logic [NUM_REG-1:0] regEn,
  output logic               ampHiZ,
  output logic               delayCharge,
  output logic               delayDischarge,
  output logic               srcSwOn,
  output logic               drnSwOn,
  output logic               comPulldown
);

  seqStrobes_t strobes;

  bias_seq_ctrl #(.NUM_REG(NUM_REG)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .uvRiseOk     (uvRiseOk),
    .uvFallLow    (uvFallLow),
    .refReady     (refReady),
    .ssDone       (ssDone),
    .faultIn      (faultIn),
    .delayReached (delayReached),
    .strobes      (strobes)
  );

  bias_seq_datapath #(.NUM_REG(NUM_REG), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .ctlIn          (ctlIn),
    .regEn          (regEn),
    .ampHiZ         (ampHiZ),
    .delayCharge    (delayCharge),
    .delayDischarge (delayDischarge),
    .srcSwOn        (srcSwOn),
    .drnSwOn        (drnSwOn),
    .comPulldown    (comPulldown)
  );

endmodule

// File: rtl/bias_sequencer_chk.sv
module bias_sequencer_chk #(
  parameter int NUM_REG = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               uvFallLow,
  input logic               refReady,
  input logic [NUM_REG-1:0] ssDone,
  input logic               faultIn,
  input logic               delayReached,
  input logic [NUM_REG-1:0] regEn,
  input logic               ampHiZ,
  input logic               delayCharge,
  input logic               delayDischarge,
  input logic               srcSwOn,
  input logic               drnSwOn,
  input logic               comPulldown
);

  assert_enables_together_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regEn[0]) |-> ((&regEn) && !ampHiZ && $past(refReady)));

  assert_uv_shutdown_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvFallLow |=> (regEn == '0 && ampHiZ && delayDischarge));

  assert_uv_switch_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvFallLow |-> ##2 (!srcSwOn && !drnSwOn && comPulldown));

  assert_charge_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delayCharge) |-> $past((&ssDone) && !faultIn));

  assert_unlock_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(comPulldown) |-> ($past(delayReached, 2) && $past(&ssDone, 2) && !$past(faultIn, 2)));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(srcSwOn && drnSwOn));

  assert_bbm_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    drnSwOn |=> !srcSwOn);

  assert_bbm_drn_R8: assert property (@(posedge clk) disable iff (!rstN)
    srcSwOn |=> !drnSwOn);

  assert_fault_rearm_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> (!delayCharge && delayDischarge));

  assert_fault_switch_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |-> ##2 (!srcSwOn && !drnSwOn));

endmodule

bind bias_sequencer bias_sequencer_chk #(.NUM_REG(NUM_REG)) i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .uvFallLow      (uvFallLow),
  .refReady       (refReady),
  .ssDone         (ssDone),
  .faultIn        (faultIn),
  .delayReached   (delayReached),
  .regEn          (regEn),
  .ampHiZ         (ampHiZ),
  .delayCharge    (delayCharge),
  .delayDischarge (delayDischarge),
  .srcSwOn        (srcSwOn),
  .drnSwOn        (drnSwOn),
  .comPulldown    (comPulldown)
);

// File: tb/test_bias_sequencer.sv
`timescale 1ns/1ps
module test_bias_sequencer;

  localparam int NUM_REG = 3;
  localparam int SYNC_STAGES = 2;
  localparam logic [NUM_REG-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvRiseOk = 1'b0, uvFallLow = 1'b0, refReady = 1'b0;
  logic [NUM_REG-1:0] ssDone = '0;
  logic faultIn = 1'b0, delayReached = 1'b0, ctlIn = 1'b0;
  logic [NUM_REG-1:0] regEn;
  logic ampHiZ, delayCharge, delayDischarge, srcSwOn, drnSwOn, comPulldown;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bias_sequencer #(.NUM_REG(NUM_REG), .SYNC_STAGES(SYNC_STAGES)) i_bias_sequencer (
    .clk(clk), .rstN(rstN), .uvRiseOk(uvRiseOk), .uvFallLow(uvFallLow),
    .refReady(refReady), .ssDone(ssDone), .faultIn(faultIn),
    .delayReached(delayReached), .ctlIn(ctlIn), .regEn(regEn),
    .ampHiZ(ampHiZ), .delayCharge(delayCharge), .delayDischarge(delayDischarge),
    .srcSwOn(srcSwOn), .drnSwOn(drnSwOn), .comPulldown(comPulldown)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // packs {src, drn, pulldown}
  function automatic logic [31:0] swState();
    return {29'd0, srcSwOn, drnSwOn, comPulldown};
  endfunction

  task automatic goOff();
    uvFallLow = 1; uvRiseOk = 0; refReady = 0; ssDone = '0;
    faultIn = 0; delayReached = 0;
    cyc(2);
    uvFallLow = 0;
    cyc(1);
  endtask

  task automatic goActive(input logic ctlLevel);
    ctlIn = ctlLevel; uvRiseOk = 1;
    cyc(2);
    refReady = 1; cyc(1);
    ssDone = ALL; cyc(1);
    delayReached = 1; cyc(1);
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(3);
    check("R1", "regEn", regEn, 0);
    check("R1", "ampHiZ", ampHiZ, 1);
    check("R1", "charge/discharge", {delayCharge, delayDischarge}, 2'b01);
    check("R1", "switches", swState(), 3'b001);
    rstN = 1;
    cyc(1);
  endtask

  task automatic t_hysteresis();
    refReady = 1; ssDone = ALL;
    cyc(4);
    check("R2", "no start without rise", regEn, 0);
    uvRiseOk = 1; cyc(1);
    uvRiseOk = 0; cyc(2);
    check("R2", "start after rise pulse", regEn, ALL);
    cyc(5);
    check("R2", "hold between thresholds", regEn, ALL);
    uvRiseOk = 1; uvFallLow = 1; cyc(1);
    check("R2", "falling wins", regEn, 0);
    goOff();
  endtask

  task automatic t_ref_and_delay();
    uvRiseOk = 1; cyc(2);
    check("R3", "waiting for reference", {ampHiZ, regEn}, {1'b1, {NUM_REG{1'b0}}});
    refReady = 1; cyc(1);
    check("R3", "enables together", {ampHiZ, regEn}, {1'b0, ALL});
    ssDone = 3'b011; cyc(3);
    check("R5", "partial soft-start", {delayCharge, delayDischarge}, 2'b01);
    ssDone = ALL; faultIn = 1; cyc(2);
    check("R5", "fault blocks charge", {delayCharge, delayDischarge}, 2'b01);
    faultIn = 0; cyc(1);
    check("R5", "charge starts", {delayCharge, delayDischarge}, 2'b10);
    ctlIn = 1; cyc(6);
    check("R6", "ctl ignored before delay", swState(), 3'b001);
    delayReached = 1; cyc(1);
    check("R6", "pulldown still on at unlock edge", swState(), 3'b001);
    cyc(1);
    check("R6", "unlocked, src selected", swState(), 3'b100);
  endtask

  task automatic t_steer();
    ctlIn = 0; cyc(SYNC_STAGES);
    check("R7", "sync lag keeps src", swState(), 3'b100);
    cyc(1);
    check("R8", "both off gap to drn", swState(), 3'b000);
    cyc(1);
    check("R7", "drn selected", swState(), 3'b010);
    ctlIn = 1; cyc(SYNC_STAGES + 1);
    check("R8", "both off gap to src", swState(), 3'b000);
    cyc(1);
    check("R7", "src selected", swState(), 3'b100);
  endtask

  task automatic t_fault();
    faultIn = 1; delayReached = 0; cyc(1);
    check("R9", "delay re-armed", {delayCharge, delayDischarge, regEn}, {2'b01, ALL});
    cyc(1);
    check("R9", "switches dropped", swState(), 3'b001);
    faultIn = 0; cyc(1);
    check("R9", "recharge", {delayCharge, delayDischarge}, 2'b10);
    cyc(2);
    check("R9", "still locked", swState(), 3'b001);
    delayReached = 1; cyc(2);
    check("R9", "unlocked again", swState(), 3'b100);
  endtask

  task automatic t_uv_fall();
    uvRiseOk = 0; uvFallLow = 1; cyc(1);
    check("R4", "rails off", {ampHiZ, delayDischarge, regEn}, {2'b11, {NUM_REG{1'b0}}});
    cyc(1);
    check("R4", "switches off", swState(), 3'b001);
    uvFallLow = 0; cyc(4);
    check("R4", "stays off", {ampHiZ, regEn}, {1'b1, {NUM_REG{1'b0}}});
    goOff();
  endtask

  task automatic t_low_at_unlock();
    goActive(1'b0);
    check("R7", "drn at unlock with ctl low", swState(), 3'b010);
    ssDone = 3'b110; cyc(2);
    check("R9", "soft-start drop locks stage", swState(), 3'b001);
    goOff();
  endtask

  initial begin
    cyc(40000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hysteresis();
    t_ref_and_delay();
    t_steer();
    t_fault();
    t_uv_fall();
    t_low_at_unlock();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule